// File: doc/BRIEF.md
# Chained Ping-Pong DMA Channel Pair

This block holds two DMA channels that take turns copying samples from a fixed peripheral data register into two separate buffers in RAM. Software loads each channel with a source address, a destination address, a transfer count and a control word. Each channel then moves one element per pulse of the pacing request it selects, or one per cycle when it is unpaced. When a channel's count runs out, it stops, flags its completion interrupt, and starts its partner from that partner's saved destination and count. The two buffers therefore fill in turn with no lost sample, while software drains whichever buffer has just been completed.

Software reaches the block through a simple word-indexed register port. Bit 3 of the index picks the channel. The low three bits pick the register: source (0), destination (1), count (2), control (3), control-and-start (4), and a shared interrupt status at offset 5 that software clears by writing ones. The source register is read through a combinational port. Each element goes out on a single memory write port, together with its transfer size. An abort input stops everything at once.

Top module: `pingpong_dma`

## Requirements
- R1: Reads at offsets 0, 1 and 2 return the channel's live source address, live destination address and remaining count. The remaining count drops by one per transfer, and the destination address shows how far the channel has advanced.
- R2: Control bits [2:1] set the size: 0 is byte, 1 is halfword, 2 is word. This size appears on mem_size with every write. Control bit 3 makes the source address advance by 1, 2 or 4 after each transfer, and control bit 4 does the same for the destination address.
- R3: Control bits [10:5] select the pacing request line. A busy channel makes exactly one transfer per one-cycle pulse on req_i[select], in the same cycle, and pulses on the other lines have no effect. The value 0x3F makes the channel transfer on every cycle.
- R4: A write to offset 4 stores bits [11:0] as the control word. If bit 0 (enable) is 1, the write also starts the channel from the saved source, destination and count. A write to offset 3 updates control bits [11:1] only and never starts a channel.
- R5: After its last transfer, a channel clears its control bit 0, which is readable, and sets its bit in the status register (bit 0 for channel 0, bit 1 for channel 1). The status bit is also driven on irq_o.
- R6: Control bit 11 names the chain target. When a channel finishes and bit 11 holds the other channel's number, that other channel is busy in the next cycle, reloaded with its saved destination and count. A request arriving in that cycle is served. When bit 11 holds the channel's own number, nothing restarts.
- R7: Writing to status offset 5 clears each status bit whose data bit is 1 and leaves the others unchanged. If a completion and a clear land in the same cycle, the completion wins.
- R8: While abort_i is high there is no memory write. Afterwards both channels are idle, with control bit 0 at 0, and any request that was pending is dropped. No chain trigger follows an abort.
- R9: When both channels want to transfer in the same cycle, channel 0 goes first. Channel 1 keeps its request and makes its transfer in a later cycle.
- R10: After reset no channel is busy, every control word reads 0, irq_o is 0, and the saved count is BUF_LEN (1024). A channel started without loading a count therefore makes 1024 transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index: bit 3 is the channel, bits [2:0] are the offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_i | input | NREQ | Pacing request pulses |
| abort_i | input | 1 | Stops both channels at once |
| src_addr | output | AW | Source address of the current transfer |
| src_data | input | 32 | Data read at src_addr, in the same cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| mem_size | output | 2 | Size of the current transfer |
| irq_o | output | 2 | Completion interrupt for each channel |

## Verification
The assertions check on every cycle that no write occurs during an abort and that both channels are idle afterwards. They also check that nothing writes while neither channel is busy, that a status bit rises only just after a memory write, and that a status bit falls only after a write of one to it. The bench scenarios cover the rest. They show the exact addresses and data of each buffer as the channels alternate under a request held on every cycle, with no cycle lost at the handoff. They also show one transfer per pulse under random gaps and noise on the other request lines, address stepping for each size, channel-0 priority, the completion winning over a clear in the same cycle, and the 1024-transfer default count.

// File: rtl/pingpong_dma.sv
module pingpong_dma #(
  parameter int AW      = 32,
  parameter int CW      = 16,
  parameter int NREQ    = 4,
  parameter int BUF_LEN = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [3:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [NREQ-1:0] req_i,
  input  logic            abort_i,
  output logic [AW-1:0]   src_addr,
  input  logic [31:0]     src_data,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  output logic [1:0]      mem_size,
  output logic [1:0]      irq_o
);
  localparam int         NCH    = 2;
  localparam int         CTW    = 12;
  localparam logic [5:0] UNPACE = 6'h3F;

  logic [AW-1:0]  cfg_rd [NCH];
  logic [AW-1:0]  cfg_wr [NCH];
  logic [CW-1:0]  cfg_cnt[NCH];
  logic [AW-1:0]  cur_rd [NCH];
  logic [AW-1:0]  cur_wr [NCH];
  logic [CW-1:0]  cur_cnt[NCH];
  logic [CTW-1:0] ctrl   [NCH];
  logic [AW-1:0]  step   [NCH];
  logic [NCH-1:0] pend, stat, hit, want, fire, last, start;
  logic [63:0]    req_ext;
  logic [2:0]     off;
  logic           rch, w1c, idx;

  assign req_ext = 64'(req_i);
  assign off     = reg_addr[2:0];
  assign rch     = reg_addr[3];
  assign w1c     = reg_we && off == 3'd5;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      hit[c]  = (ctrl[c][10:5] == UNPACE) || req_ext[ctrl[c][10:5]];
      want[c] = ctrl[c][0] && (pend[c] || hit[c]) && !abort_i;
      case (ctrl[c][2:1])
        2'd0:    step[c] = AW'(1);
        2'd1:    step[c] = AW'(2);
        default: step[c] = AW'(4);
      endcase
    end
    fire[0] = want[0];
    fire[1] = want[1] && !want[0];
    for (int c = 0; c < NCH; c++)
      last[c] = fire[c] && cur_cnt[c] == CW'(1);
    for (int c = 0; c < NCH; c++)
      start[c] = (reg_we && rch == 1'(c) && off == 3'd4 && reg_wdata[0]) ||
                 (last[1-c] && ctrl[1-c][11] == 1'(c));
  end

  assign idx       = fire[1];
  assign mem_we    = |fire;
  assign mem_addr  = cur_wr[idx];
  assign src_addr  = cur_rd[idx];
  assign mem_wdata = src_data;
  assign mem_size  = ctrl[idx][2:1];
  assign irq_o     = stat;

  always_comb begin
    case (off)
      3'd0:    reg_rdata = 32'(cur_rd[rch]);
      3'd1:    reg_rdata = 32'(cur_wr[rch]);
      3'd2:    reg_rdata = 32'(cur_cnt[rch]);
      3'd3,
      3'd4:    reg_rdata = 32'(ctrl[rch]);
      3'd5:    reg_rdata = 32'(stat);
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        cfg_rd[c]  <= '0;
        cfg_wr[c]  <= '0;
        cfg_cnt[c] <= CW'(BUF_LEN);
        cur_rd[c]  <= '0;
        cur_wr[c]  <= '0;
        cur_cnt[c] <= '0;
        ctrl[c]    <= '0;
      end
      pend <= '0;
      stat <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (reg_we && rch == 1'(c)) begin
          case (off)
            3'd0: cfg_rd[c]  <= AW'(reg_wdata);
            3'd1: cfg_wr[c]  <= AW'(reg_wdata);
            3'd2: cfg_cnt[c] <= CW'(reg_wdata);
            3'd3: ctrl[c][CTW-1:1] <= reg_wdata[CTW-1:1];
            3'd4: ctrl[c] <= reg_wdata[CTW-1:0];
            default: ;
          endcase
        end
        if (fire[c]) begin
          cur_cnt[c] <= cur_cnt[c] - CW'(1);
          if (ctrl[c][3]) cur_rd[c] <= cur_rd[c] + step[c];
          if (ctrl[c][4]) cur_wr[c] <= cur_wr[c] + step[c];
        end
        if (last[c]) ctrl[c][0] <= 1'b0;
        if (!ctrl[c][0] || last[c]) pend[c] <= 1'b0;
        else if (fire[c])           pend[c] <= pend[c] && hit[c];
        else                        pend[c] <= pend[c] || hit[c];
        if (start[c]) begin
          ctrl[c][0] <= cfg_cnt[c] != '0;
          cur_rd[c]  <= cfg_rd[c];
          cur_wr[c]  <= cfg_wr[c];
          cur_cnt[c] <= cfg_cnt[c];
          pend[c]    <= 1'b0;
        end
        if (abort_i) begin
          ctrl[c][0] <= 1'b0;
          pend[c]    <= 1'b0;
        end
        if (last[c])                    stat[c] <= 1'b1;
        else if (w1c && reg_wdata[c])   stat[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pingpong_dma_chk.sv
module pingpong_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        abort_i,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_we,
  input logic [1:0]  irq_o,
  input logic [1:0]  busy
);
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |-> !mem_we);

  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> busy == 2'b00);

  a_r3_write_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy != 2'b00);

  a_r5_irq0_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> $past(mem_we));

  a_r5_irq1_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[1]) |-> $past(mem_we));

  a_r7_irq0_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o[0]) |-> $past(reg_we && reg_addr[2:0] == 3'd5 && reg_wdata[0]));

  a_r7_irq1_cleared_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o[1]) |-> $past(reg_we && reg_addr[2:0] == 3'd5 && reg_wdata[1]));
endmodule

bind pingpong_dma pingpong_dma_chk i_chk (
  .clk(clk), .rst_n(rst_n), .abort_i(abort_i), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mem_we(mem_we),
  .irq_o(irq_o), .busy({ctrl[1][0], ctrl[0][0]})
);

// File: tb/test_pingpong_dma.sv
module test_pingpong_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  req_i = '0;
  logic        abort_i = 1'b0;
  logic [31:0] src_addr, src_data, mem_addr, mem_wdata;
  logic        mem_we;
  logic [1:0]  mem_size, irq_o;

  int checks = 0, failures = 0, nw = 0;
  bit done = 0;
  logic [31:0] wa [4096];
  logic [31:0] wd [4096];
  logic [1:0]  wsz[4096];

  always #2 clk = ~clk;

  function automatic logic [31:0] sfun(logic [31:0] a);
    return (a * 32'h0000_9E37) ^ 32'h1357_2468;
  endfunction
  assign src_data = sfun(src_addr);

  pingpong_dma i_pingpong_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_i(req_i),
    .abort_i(abort_i), .src_addr(src_addr), .src_data(src_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_size(mem_size), .irq_o(irq_o)
  );

  always @(posedge clk) if (rst_n && mem_we && nw < 4096) begin
    wa[nw] <= mem_addr; wd[nw] <= mem_wdata; wsz[nw] <= mem_size; nw <= nw + 1;
  end

  function automatic logic [31:0] mkctrl(bit en, logic [1:0] sz, bit ir, bit iw,
                                         logic [5:0] sel, bit ch);
    return {20'd0, ch, sel, iw, ir, sz, en};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic pulse(logic [3:0] m);
    @(negedge clk); req_i = m;
    @(negedge clk); req_i = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(bit ch, logic [31:0] s, logic [31:0] d, logic [31:0] n);
    wr({ch, 3'd0}, s); wr({ch, 3'd1}, d); wr({ch, 3'd2}, n);
  endtask

  task automatic chk_wr(string tag, int i, logic [31:0] ea, logic [31:0] ed, logic [1:0] es);
    check({tag, " addr"}, wa[i], ea);
    check({tag, " data"}, wd[i], ed);
    check({tag, " size"}, 32'(wsz[i]), 32'(es));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, base, seed;
    int m, cnt, sel;
    seed = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    idle(1);
    check("R10 irq reset", 32'(irq_o), 0);
    check("R10 no write at reset", 32'(mem_we), 0);
    rd(4'h3, v); check("R10 ctrl0 reset", v, 0);
    rd(4'hB, v); check("R10 ctrl1 reset", v, 0);

    // R10 default count of 1024, unpaced
    m = nw;
    wr(4'h4, mkctrl(1, 2'd1, 0, 1, 6'h3F, 0));
    idle(1100);
    check("R10 default count writes", nw - m, 1024);
    check("R10 last addr", wa[m+1023], 32'd2046);
    check("R5 irq0 after default run", 32'(irq_o), 32'd1);
    rd(4'h3, v); check("R5 enable cleared", v, mkctrl(0, 2'd1, 0, 1, 6'h3F, 0));
    wr(4'h5, 32'd0); check("R7 zero write keeps", 32'(irq_o), 1);
    wr(4'h5, 32'd1); idle(1); check("R7 one write clears", 32'(irq_o), 0);

    // R4 plain control alias does not start
    setup(0, 32'h4000_0000, 32'h100, 3);
    m = nw;
    wr(4'h3, mkctrl(1, 2'd1, 0, 1, 6'h3F, 0));
    idle(5);
    check("R4 plain ctrl no writes", nw - m, 0);
    rd(4'h3, v); check("R4 plain ctrl stored, not enabled", v, mkctrl(0, 2'd1, 0, 1, 6'h3F, 0));

    // R2 sizes and increments
    for (int sz = 0; sz < 3; sz++) begin
      setup(0, 32'h4000_0010, 32'h300, 3);
      m = nw;
      wr(4'h4, mkctrl(1, 2'(sz), 1, 1, 6'h3F, 0));
      idle(6);
      check("R2 write count", nw - m, 3);
      for (int i = 0; i < 3; i++)
        chk_wr("R2 step", m + i, 32'h300 + (i << sz), sfun(32'h4000_0010 + (i << sz)), 2'(sz));
      wr(4'h5, 32'd1);
    end

    // R3 selected line only, one per pulse; R1 readback
    setup(0, 32'h4000_0000, 32'h500, 5);
    m = nw;
    wr(4'h4, mkctrl(1, 2'd1, 0, 1, 6'd2, 0));
    pulse(4'b1011); idle(2);
    check("R3 other lines ignored", nw - m, 0);
    pulse(4'b0100); idle(1); pulse(4'b0100); idle(1);
    check("R3 one per pulse", nw - m, 2);
    rd(4'h2, v); check("R1 remaining count", v, 3);
    rd(4'h1, v); check("R1 live dest", v, 32'h504);
    rd(4'h0, v); check("R1 live src", v, 32'h4000_0000);
    wr(4'h8 | 4'h4, 32'd0); wr(4'h4, 32'd0);

    // R3 constrained random pacing
    for (int t = 0; t < 8; t++) begin
      cnt  = 1 + int'($urandom % 6);
      sel  = int'($urandom % 4);
      base = 32'h1000 + (($urandom % 256) << 1);
      setup(0, 32'h4000_0020, base, cnt);
      m = nw;
      wr(4'h4, mkctrl(1, 2'd1, 0, 1, 6'(sel), 0));
      for (int p = 0; p < cnt + 2; p++) begin
        logic [3:0] mask;
        mask = 4'(1 << sel);
        if ($urandom % 2) mask = mask | 4'(1 << ((sel + 1 + int'($urandom % 3)) % 4));
        pulse(mask);
        idle(1 + int'($urandom % 3));
      end
      check("R3 random count", nw - m, cnt);
      for (int i = 0; i < cnt; i++)
        chk_wr("R3 random", m + i, base + 2 * i, sfun(32'h4000_0020), 2'd1);
      check("R5 random irq", 32'(irq_o), 1);
      wr(4'h5, 32'd1);
    end

    // R7 completion wins over clear in the same cycle
    setup(0, 32'h4000_0000, 32'h700, 1);
    wr(4'h4, mkctrl(1, 2'd1, 0, 1, 6'h3F, 0));
    wr(4'h5, 32'd1);
    idle(1);
    check("R7 set wins over clear", 32'(irq_o), 1);
    wr(4'h5, 32'd1);

    // R6 self chain does not restart
    setup(0, 32'h4000_0000, 32'h800, 2);
    m = nw;
    wr(4'h4, mkctrl(1, 2'd1, 0, 1, 6'h3F, 0));
    idle(8);
    check("R6 self chain stops", nw - m, 2);
    wr(4'h5, 32'd1);

    // R9 channel 0 priority
    setup(0, 32'h4000_0000, 32'h900, 4);
    setup(1, 32'h4000_0000, 32'hA00, 4);
    wr(4'h4, mkctrl(1, 2'd1, 0, 1, 6'd1, 0));
    wr(4'hC, mkctrl(1, 2'd1, 0, 1, 6'd1, 1));
    m = nw;
    pulse(4'b0010); idle(2);
    check("R9 both served", nw - m, 2);
    check("R9 ch0 first", wa[m], 32'h900);
    check("R9 ch1 later", wa[m+1], 32'hA00);
    wr(4'h4, 32'd0); wr(4'hC, 32'd0);

    // R6 ping-pong with a request on every cycle
    setup(0, 32'h4000_0000, 32'h100, 4);
    setup(1, 32'h4000_0000, 32'h200, 4);
    wr(4'hC, mkctrl(0, 2'd1, 0, 1, 6'd0, 0));
    wr(4'h4, mkctrl(1, 2'd1, 0, 1, 6'd0, 1));
    m = nw;
    @(negedge clk); req_i = 4'b0001;
    repeat (20) @(negedge clk);
    req_i = '0;
    check("R6 no gap at handoff", nw - m, 20);
    for (int k = 0; k < 20; k++)
      chk_wr("R6 pingpong", m + k, (((k / 4) % 2) ? 32'h200 : 32'h100) + 2 * (k % 4),
             sfun(32'h4000_0000), 2'd1);
    check("R5 both irqs", 32'(irq_o), 3);
    rd(4'hA, v); check("R6 partner reloaded count", v, 4);

    // R8 abort
    m = nw;
    @(negedge clk); abort_i = 1'b1; req_i = 4'b0001;
    @(negedge clk); abort_i = 1'b0; req_i = '0;
    check("R8 no write during abort", nw - m, 0);
    pulse(4'b0001); idle(3);
    check("R8 idle after abort", nw - m, 0);
    rd(4'hB, v); check("R8 ch1 disabled", 32'(v[0]), 0);
    rd(4'h3, v); check("R8 ch0 disabled", 32'(v[0]), 0);
    check("R8 status kept", 32'(irq_o), 3);
    wr(4'h5, 32'd3); idle(1);
    check("R7 both cleared", 32'(irq_o), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule